// File: doc/BRIEF.md
# Interrupt Cause Aggregator

This block gathers sixty-four level-sensitive interrupt sources into one 64-bit cause vector, qualifies that vector with a 64-bit processor mask, and drives a single registered interrupt line to the CPU. Four of the sixty-four cause positions are not taken from the general source bus. Each of them is instead the OR of one group of eight general-purpose I/O interrupt pins. A fixed set of positions is reserved and is forced to zero.

Software reaches the block through a simple register port with five locations. Two locations hold the mask halves. Two give a view of the cause halves. The fifth is a summary read that returns whichever cause half holds the pending masked interrupts. Flag bits in that word tell which half was returned, or whether both halves have work, so that an interrupt handler needs only one access to find its way. Every read returns its data one cycle after the request.

Top module: `intc_cause_agg`

## Requirements
- R1: After reset the mask is zero, the cause vector is zero, `irq_o` is low and `rd_valid` is low.
- R2: The cause vector samples the source levels on each clock, so a source change is visible in a read issued one cycle later, and a dropped source clears its bit.
- R3: Cause bits 29 to 31, 51 to 55 and 61 to 63 are reserved and always read as zero, whatever the sources do.
- R4: Cause bits 56, 57, 58 and 59 are the OR of GPIO pins 0-7, 8-15, 16-23 and 24-31 respectively. Bits 59:56 of `src_i` have no effect.
- R5: Address 0 writes and reads mask bits 31:0 and address 1 writes and reads mask bits 63:32. A write to one half leaves the other half unchanged. After reset both halves read zero.
- R6: A read at address 2 returns cause bits 31:0 and a read at address 3 returns cause bits 63:32. `rd_valid` is high for exactly the one cycle that follows `rd_en`.
- R7: `irq_o` is the OR of (cause AND mask), registered. It follows a change of the cause or of the mask one cycle later.
- R8: A summary read (address 4) with no masked cause bit pending returns cause bits 31:0 unchanged.
- R9: A summary read with masked bits pending only in the low half returns cause bits 31:0 with bit 31 clear.
- R10: A summary read with masked bits pending only in the high half returns cause bits 63:32 with bit 30 set.
- R11: A summary read with masked bits pending in both halves returns cause bits 31:0 with bit 31 set.
- R12: Reads of addresses 5 to 7 return zero. Writes to addresses 2 to 7 change neither the mask nor the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level interrupt sources, one per cause bit |
| gpio_i | input | 32 | GPIO interrupt pin levels, grouped by eight |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Registered CPU interrupt line |

## Verification
The assertions assume that the source and GPIO levels are only meaningful once reset has been released for a cycle. Because of this, the GPIO grouping check starts one cycle after reset. They also assume that `wr_en` and `rd_en` are never raised in the same cycle. The stimulus holds every input at zero during reset. It changes inputs only on the falling edge and keeps reads and writes in separate cycles. Before any cause or summary read, it waits two cycles after changing the sources.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;
  localparam int SRC_W    = 64;
  localparam int HALF_W   = 32;
  localparam int GPIO_W   = 32;
  localparam int GRP_W    = 8;
  localparam int GRP_N    = GPIO_W / GRP_W;
  localparam int GPIO_LSB = 56;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAUSE_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAUSE_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd4;

  localparam int FLAG_BOTH = 31;
  localparam int FLAG_HIGH = 30;

  function automatic logic [SRC_W-1:0] rsvd_bits();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_W; i++)
      if ((i >= 29 && i <= 31) || (i >= 51 && i <= 55) || (i >= 61 && i <= 63))
        m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [SRC_W-1:0] RSVD_MASK = rsvd_bits();
endpackage

// File: rtl/intc_cause_collect.sv
module intc_cause_collect
  import intc_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_i,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic [SRC_W-1:0] cause_q
);
  logic [GRP_N-1:0] grp_any;
  logic [SRC_W-1:0] cause_d;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_any[g] = |gpio_i[g*GRP_W +: GRP_W];
  end

  always_comb begin
    cause_d = src_i;
    cause_d[GPIO_LSB +: GRP_N] = grp_any;
    cause_d = cause_d & ~RSVD_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_d;
  end
endmodule

// File: rtl/intc_mask_regs.sv
module intc_mask_regs
  import intc_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [SRC_W-1:0]  mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK_LO) mask_q[HALF_W-1:0] <= wdata;
      if (addr == A_MASK_HI) mask_q[SRC_W-1:HALF_W] <= wdata;
    end
  end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  cause_q,
  input  logic [SRC_W-1:0]  mask_q,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data
);
  logic [SRC_W-1:0]  pend;
  logic              pend_lo, pend_hi;
  logic [HALF_W-1:0] summary, rd_d;

  assign pend    = cause_q & mask_q;
  assign pend_lo = |pend[HALF_W-1:0];
  assign pend_hi = |pend[SRC_W-1:HALF_W];

  always_comb begin
    summary = cause_q[HALF_W-1:0];
    if (pend_hi && !pend_lo) begin
      summary = cause_q[SRC_W-1:HALF_W];
      summary[FLAG_HIGH] = 1'b1;
    end else if (pend_hi && pend_lo) begin
      summary[FLAG_BOTH] = 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_MASK_LO:  rd_d = mask_q[HALF_W-1:0];
      A_MASK_HI:  rd_d = mask_q[SRC_W-1:HALF_W];
      A_CAUSE_LO: rd_d = cause_q[HALF_W-1:0];
      A_CAUSE_HI: rd_d = cause_q[SRC_W-1:HALF_W];
      A_SUMMARY:  rd_d = summary;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/intc_cause_agg.sv
module intc_cause_agg
  import intc_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data,
  output logic              irq_o
);
  logic [SRC_W-1:0] cause_q;
  logic [SRC_W-1:0] mask_q;

  intc_cause_collect u_collect (
    .clk(clk), .rst(rst), .src_i(src_i), .gpio_i(gpio_i), .cause_q(cause_q)
  );

  intc_mask_regs u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .mask_q(mask_q)
  );

  intc_read_mux u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cause_q(cause_q),
    .mask_q(mask_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(cause_q & mask_q);
  end
endmodule

// File: rtl/intc_cause_agg_chk.sv
module intc_cause_agg_chk
  import intc_agg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SRC_W-1:0]  cause_q,
  input logic [SRC_W-1:0]  mask_q,
  input logic [GPIO_W-1:0] gpio_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic [HALF_W-1:0] rd_data,
  input logic              irq_o
);
  logic live, last_sum;
  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= 1'b0;
      last_sum <= 1'b0;
    end else begin
      live     <= 1'b1;
      last_sum <= rd_en && (addr == A_SUMMARY);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cause_q & RSVD_MASK) == '0);  // R3

  AST_GPIO_GROUP0: assert property (@(posedge clk) disable iff (rst)
    live |-> cause_q[GPIO_LSB] == $past(|gpio_i[GRP_W-1:0]));  // R4

  AST_MASK_LO_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MASK_HI) |=> $stable(mask_q[HALF_W-1:0]));  // R5

  AST_MASK_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != A_MASK_HI) |=> $stable(mask_q[SRC_W-1:HALF_W]));  // R5

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);  // R6

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    live |-> irq_o == $past((cause_q & mask_q) != '0));  // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && last_sum) |-> !(rd_data[FLAG_BOTH] && rd_data[FLAG_HIGH]));  // R11
endmodule

bind intc_cause_agg intc_cause_agg_chk u_chk (
  .clk(clk), .rst(rst), .cause_q(cause_q), .mask_q(mask_q), .gpio_i(gpio_i),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/intc_cause_agg_tb.sv
module intc_cause_agg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic [31:0] gpio_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  intc_cause_agg u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .gpio_i(gpio_i), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data whenever the design returns a word
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    rd(3'd0, 32'h0, "R1 mask lo reset");
    rd(3'd1, 32'h0, "R5 mask hi reset");
    rd(3'd2, 32'h0, "R1 cause lo reset");

    // all sources high, GPIO quiet
    src_i = '1; settle();
    rd(3'd2, 32'h1FFF_FFFF, "R3 cause lo reserved");
    rd(3'd3, 32'h1007_FFFF, "R4 cause hi src 59:56 ignored");
    gpio_i = 32'h0100_0080; settle();
    rd(3'd3, 32'h1907_FFFF, "R4 gpio groups 0 and 3");
    gpio_i = 32'h0000_8000; settle();
    rd(3'd3, 32'h1207_FFFF, "R4 gpio group 1");
    gpio_i = '0;
    src_i = '0; settle();
    rd(3'd2, 32'h0, "R2 dropped sources clear");

    // mask halves
    wr(3'd0, 32'hDEAD_BEEF);
    wr(3'd1, 32'h1234_5678);
    rd(3'd0, 32'hDEAD_BEEF, "R5 mask lo kept");
    rd(3'd1, 32'h1234_5678, "R5 mask hi");
    wr(3'd0, 32'h0000_0001);
    rd(3'd1, 32'h1234_5678, "R5 hi kept after lo write");

    // read-only / unused locations
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd2, 32'h0, "R12 cause unchanged by write");
    rd(3'd0, 32'h1, "R12 mask lo unchanged");
    rd(3'd1, 32'h1234_5678, "R12 mask hi unchanged");
    rd(3'd5, 32'h0, "R12 unused addr reads zero");

    // summary read cases: mask lo=bit0, mask hi=bit1 (cause bit 33)
    wr(3'd1, 32'h0000_0002);
    src_i = 64'h20; settle();
    check("R7 irq low unmasked", {31'd0, irq_o}, 32'd0);
    rd(3'd4, 32'h0000_0020, "R8 summary none pending");
    src_i = 64'h1; settle();
    check("R7 irq high", {31'd0, irq_o}, 32'd1);
    rd(3'd4, 32'h0000_0001, "R9 summary low only");
    src_i = 64'h2_0000_0000; settle();
    rd(3'd4, 32'h4000_0002, "R10 summary high only");
    check("R7 irq high from hi half", {31'd0, irq_o}, 32'd1);
    src_i = 64'h2_0000_0001; settle();
    rd(3'd4, 32'h8000_0001, "R11 summary both halves");
    rd(3'd3, 32'h0000_0002, "R6 cause hi read");
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    settle();
    check("R7 irq drops with mask", {31'd0, irq_o}, 32'd0);

    settle();
    check("R6 all reads returned", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule